// File: doc/BRIEF.md
# Demodulator Power-Up and Init Sequencer

This block brings an external demodulator chip out of power-down and loads its start-up registers. On a start strobe it samples a mode code and walks through a fixed bring-up order: hold the chip's reset pin low, switch the complementary power pins on, wait for the supply to settle, release reset, wait for the chip's internal power-on reset, check that the chip answers on the serial bus, and write three fixed register blocks. Each bus access is handed to an external register-access engine as a single request (one probe read or one register write). The engine answers with a done pulse and a success flag. The serial bus itself is not part of this block.

Debug modes stop the sequence after a chosen stage, or run the probe alone on a chip that is already powered. A shutdown mode removes power in one cycle. A mode that only reads the status changes nothing. Delays are given in milliseconds and converted to clock cycles from a clock-frequency parameter. A stage output holds the last step that completed, so a failed bring-up can be traced to the step where it stopped.

Top module: `demod_bringup`

## Requirements
- R1: While `rst` is high and after it falls, `chip_reset_n`=0, `pwr_en`=0, `pwr_off`=1, `req_valid`=0, `status`=0x00, `stage`=0, `busy`=0 and `error`=0.
- R2: `pwr_en` and `pwr_off` are always complementary. On a run that powers the chip, `stage` steps through 1 (reset held low), 2 (power on), 3 (reset released) and 4 (power-on wait over) in that order, and `pwr_en` rises only while `chip_reset_n` is low.
- R3: `chip_reset_n` rises no earlier than POWER_MS·(CLK_HZ/1000) cycles after `pwr_en` rises, and no more than 4 cycles later than that.
- R4: The first bus request comes no earlier than POR_MS·(CLK_HZ/1000) cycles after `chip_reset_n` rises, and no more than 6 cycles later. No request is raised while `chip_reset_n` is low.
- R5: The probe is a read request (`req_write`=0) of register 0xA2 at device address `req_dev`=0x08. If the probe fails (`req_ok`=0 with `req_done`), `error` is set, `busy` falls, no further request is made, and `stage` keeps the last completed step. A successful probe sets `stage` to 5.
- R6: `req_valid` stays high, with `req_reg` and `req_data` stable, until `req_done`. Each register write is a separate request (`req_write`=1) addressed to the block's start register plus the byte offset.
- R7: The writes come in this order: 06 0B 17 38 9F D9 80 to registers 0x06..0x0C (block 0), then 07 09 39 4F 00 65 B7 10 to 0x07..0x0E (block 1), then 0F 0C 09 to 0x0F..0x11 (block 2). When a block is finished, `stage` becomes 6, 7 or 8 respectively.
- R8: Mode 0x01 runs the whole sequence. On success it ends with `status`=0x03 (bit 0 started, bit 1 loaded) and `stage`=9. A failed write sets `error` and stops the run with `status` unchanged.
- R9: Mode 0x81 stops after stage 4 with no request. Mode 0x82 stops after the probe (stage 5). Mode 0x83 stops after block 0 (stage 6). None of these changes `status`.
- R10: Mode 0x84 does only the probe. It leaves the pins unchanged, sets `stage` to 0 at the start and to 5 on success.
- R11: Mode 0x80 changes no pin and does not change `status`, `stage` or `error`.
- R12: Mode 0x00 drives, on the next clock, `chip_reset_n`=0, `pwr_en`=0 and `pwr_off`=1. It clears `status` bits 0 and 1, sets `stage`=10 and does not raise `busy`.
- R13: A start strobe that arrives while `busy` is high is ignored.
- R14: Any mode code not listed above sets `error` and leaves the pins, `status` and `stage` unchanged. An accepted mode other than 0x80 clears `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, sampled when idle |
| mode | input | 8 | Mode code sampled with `start` |
| chip_reset_n | output | 1 | Reset pin to the demodulator, active low |
| pwr_en | output | 1 | Power-enable pin |
| pwr_off | output | 1 | Power-disable pin (complement of `pwr_en`) |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | 1 = register write, 0 = probe read |
| req_dev | output | 7 | Device address on the bus |
| req_reg | output | 8 | Register address |
| req_data | output | 8 | Write data |
| req_done | input | 1 | Engine finished the pending request |
| req_ok | input | 1 | Engine result, valid with `req_done` |
| status | output | 8 | Status byte: bit 0 started, bit 1 loaded |
| stage | output | 4 | Last completed step code |
| busy | output | 1 | Sequence in progress |
| error | output | 1 | Last accepted command failed or was unknown |

## Verification
A table of mode runs drives each debug mode and the full mode in turn. An engine model fails a chosen request in some runs: the probe in a power mode, the probe in probe-only mode, and a write in the middle of block 1. This separates a sequencer that stops at the right stage from one that keeps going or reports the wrong step. Every logged request is compared with the expected probe and write list, which catches wrong order, wrong addresses and wrong data. The bench measures the delay windows from pin edges, so a wrong cycles-per-millisecond conversion is caught. Directed cases cover the status-only mode, an unknown code, a shutdown sent during a run and a reset during a run.

// File: rtl/demod_boot_pkg.sv
package demod_boot_pkg;

  typedef enum logic [3:0] {
    STG_NONE  = 4'd0,
    STG_RST   = 4'd1,
    STG_PWR   = 4'd2,
    STG_REL   = 4'd3,
    STG_POR   = 4'd4,
    STG_PROBE = 4'd5,
    STG_BLK0  = 4'd6,
    STG_BLK1  = 4'd7,
    STG_BLK2  = 4'd8,
    STG_DONE  = 4'd9,
    STG_OFF   = 4'd10
  } stage_t;

  localparam logic [7:0] MODE_OFF        = 8'h00;
  localparam logic [7:0] MODE_FULL       = 8'h01;
  localparam logic [7:0] MODE_PEEK       = 8'h80;
  localparam logic [7:0] MODE_PWR_ONLY   = 8'h81;
  localparam logic [7:0] MODE_TO_PROBE   = 8'h82;
  localparam logic [7:0] MODE_TO_BLK0    = 8'h83;
  localparam logic [7:0] MODE_PROBE_ONLY = 8'h84;

  localparam logic [7:0] PROBE_REG  = 8'hA2;
  localparam int         NUM_BLOCKS = 3;
  localparam int         INIT_BYTES = 18;

  // first global byte index, length and start register of each block
  localparam int         BLK_FIRST [NUM_BLOCKS] = '{0, 7, 15};
  localparam int         BLK_LEN   [NUM_BLOCKS] = '{7, 8, 3};
  localparam logic [7:0] BLK_REG   [NUM_BLOCKS] = '{8'h06, 8'h07, 8'h0F};

  function automatic logic [7:0] init_byte(input int i);
    case (i)
      0: return 8'h06;  1: return 8'h0B;  2: return 8'h17;  3: return 8'h38;
      4: return 8'h9F;  5: return 8'hD9;  6: return 8'h80;
      7: return 8'h07;  8: return 8'h09;  9: return 8'h39; 10: return 8'h4F;
      11: return 8'h00; 12: return 8'h65; 13: return 8'hB7; 14: return 8'h10;
      15: return 8'h0F; 16: return 8'h0C; 17: return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/boot_ms_timer.sv
module boot_ms_timer #(
  parameter int CLK_HZ = 200_000_000,
  parameter int MS_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            done
);
  localparam int CPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int CW  = $clog2(CPM + 1);

  logic [CW-1:0]   cyc_q;
  logic [MS_W-1:0] left_q;
  logic            run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        cyc_q  <= '0;
        left_q <= ms;
        run_q  <= (ms != '0);
        done   <= (ms == '0);
      end else if (run_q) begin
        if (cyc_q == CW'(CPM - 1)) begin
          cyc_q <= '0;
          if (left_q == MS_W'(1)) begin
            run_q <= 1'b0;
            done  <= 1'b1;
          end else begin
            left_q <= left_q - MS_W'(1);
          end
        end else begin
          cyc_q <= cyc_q + CW'(1);
        end
      end
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/boot_init_table.sv
module boot_init_table
  import demod_boot_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       wr_data,
  output logic [7:0]       wr_reg,
  output logic [1:0]       blk,
  output logic             last
);
  int sel;
  int off;

  always_comb begin
    sel = 0;
    for (int b = 1; b < NUM_BLOCKS; b++)
      if (int'(idx) >= BLK_FIRST[b]) sel = b;
    off     = int'(idx) - BLK_FIRST[sel];
    wr_data = init_byte(int'(idx));
    wr_reg  = BLK_REG[sel] + 8'(off);
    blk     = 2'(sel);
    last    = (off == BLK_LEN[sel] - 1);
  end

endmodule

// File: rtl/demod_bringup.sv
module demod_bringup
  import demod_boot_pkg::*;
#(
  parameter int         CLK_HZ   = 200_000_000,
  parameter int         POWER_MS = 30,
  parameter int         POR_MS   = 50,
  parameter logic [6:0] DEV_ADDR = 7'h08
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] mode,
  output logic       chip_reset_n,
  output logic       pwr_en,
  output logic       pwr_off,
  output logic       req_valid,
  output logic       req_write,
  output logic [6:0] req_dev,
  output logic [7:0] req_reg,
  output logic [7:0] req_data,
  input  logic       req_done,
  input  logic       req_ok,
  output logic [7:0] status,
  output logic [3:0] stage,
  output logic       busy,
  output logic       error
);
  localparam int MS_MAX = (POWER_MS > POR_MS) ? POWER_MS : POR_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam int IDX_W  = $clog2(INIT_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_SETTLE, S_POR, S_PROBE, S_PWAIT, S_ISSUE, S_WWAIT, S_DONE
  } state_t;

  state_t          state;
  stage_t          stage_q;
  logic [7:0]      run_mode;
  logic [IDX_W-1:0] idx;
  logic            tmr_load;
  logic [MS_W-1:0] tmr_ms;
  logic            tmr_done;
  logic [7:0]      tbl_data;
  logic [7:0]      tbl_reg;
  logic [1:0]      tbl_blk;
  logic            tbl_last;

  boot_ms_timer #(.CLK_HZ(CLK_HZ), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .ms(tmr_ms), .done(tmr_done)
  );

  boot_init_table #(.IDX_W(IDX_W)) u_table (
    .idx(idx), .wr_data(tbl_data), .wr_reg(tbl_reg), .blk(tbl_blk), .last(tbl_last)
  );

  assign req_dev = DEV_ADDR;
  assign stage   = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      stage_q      <= STG_NONE;
      run_mode     <= MODE_PEEK;
      idx          <= '0;
      tmr_load     <= 1'b0;
      tmr_ms       <= '0;
      chip_reset_n <= 1'b0;
      pwr_en       <= 1'b0;
      pwr_off      <= 1'b1;
      req_valid    <= 1'b0;
      req_write    <= 1'b0;
      req_reg      <= '0;
      req_data     <= '0;
      status       <= '0;
      busy         <= 1'b0;
      error        <= 1'b0;
    end else begin
      tmr_load <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          case (mode)
            MODE_PEEK: ;
            MODE_OFF: begin
              chip_reset_n <= 1'b0;
              pwr_en       <= 1'b0;
              pwr_off      <= 1'b1;
              status[1:0]  <= 2'b00;
              stage_q      <= STG_OFF;
              error        <= 1'b0;
            end
            MODE_FULL, MODE_PWR_ONLY, MODE_TO_PROBE, MODE_TO_BLK0: begin
              run_mode     <= mode;
              busy         <= 1'b1;
              error        <= 1'b0;
              chip_reset_n <= 1'b0;
              stage_q      <= STG_RST;
              state        <= S_PWR;
            end
            MODE_PROBE_ONLY: begin
              run_mode <= mode;
              busy     <= 1'b1;
              error    <= 1'b0;
              stage_q  <= STG_NONE;
              state    <= S_PROBE;
            end
            default: error <= 1'b1;
          endcase
        end
        S_PWR: begin
          pwr_en   <= 1'b1;
          pwr_off  <= 1'b0;
          stage_q  <= STG_PWR;
          tmr_load <= 1'b1;
          tmr_ms   <= MS_W'(POWER_MS);
          state    <= S_SETTLE;
        end
        S_SETTLE: if (tmr_done) begin
          chip_reset_n <= 1'b1;
          stage_q      <= STG_REL;
          tmr_load     <= 1'b1;
          tmr_ms       <= MS_W'(POR_MS);
          state        <= S_POR;
        end
        S_POR: if (tmr_done) begin
          stage_q <= STG_POR;
          if (run_mode == MODE_PWR_ONLY) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_PROBE;
          end
        end
        S_PROBE: begin
          req_valid <= 1'b1;
          req_write <= 1'b0;
          req_reg   <= PROBE_REG;
          req_data  <= 8'h00;
          state     <= S_PWAIT;
        end
        S_PWAIT: if (req_done) begin
          req_valid <= 1'b0;
          if (!req_ok) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            stage_q <= STG_PROBE;
            if (run_mode == MODE_TO_PROBE || run_mode == MODE_PROBE_ONLY) begin
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              idx   <= '0;
              state <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_reg   <= tbl_reg;
          req_data  <= tbl_data;
          state     <= S_WWAIT;
        end
        S_WWAIT: if (req_done) begin
          req_valid <= 1'b0;
          if (!req_ok) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (tbl_last) begin
            stage_q <= stage_t'(4'(STG_BLK0) + {2'b00, tbl_blk});
            if (tbl_blk == 2'(NUM_BLOCKS - 1)) begin
              state <= S_DONE;
            end else if (tbl_blk == 2'd0 && run_mode == MODE_TO_BLK0) begin
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= S_ISSUE;
            end
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= S_ISSUE;
          end
        end
        S_DONE: begin
          status[1:0] <= 2'b11;
          stage_q     <= STG_DONE;
          busy        <= 1'b0;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_pins_complement_R2: assert property (@(posedge clk) disable iff (rst)
    pwr_en != pwr_off);

  assert_power_while_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> !chip_reset_n);

  assert_release_powered_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_reset_n) |-> pwr_en);

  assert_no_req_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> chip_reset_n);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_done |=> req_valid && $stable(req_reg) && $stable(req_data));

  assert_full_status_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && stage_q == STG_DONE |-> status[1:0] == 2'b11 && !error);

  assert_shutdown_pins_R12: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && start && mode == MODE_OFF |=>
      !pwr_en && pwr_off && !chip_reset_n && status[1:0] == 2'b00);

  assert_busy_ignores_start_R13: assert property (@(posedge clk) disable iff (rst)
    state != S_IDLE && start |=> run_mode == $past(run_mode));

  assert_unknown_keeps_pins_R14: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && start && mode != MODE_OFF && mode != MODE_FULL &&
    mode != MODE_PEEK && mode != MODE_PWR_ONLY && mode != MODE_TO_PROBE &&
    mode != MODE_TO_BLK0 && mode != MODE_PROBE_ONLY |=>
      error && !busy && $stable(pwr_en) && $stable(chip_reset_n));

endmodule

// File: tb/demod_bringup_test.sv
module demod_bringup_test;
  localparam int CLK_HZ = 2000;
  localparam int CPM    = CLK_HZ / 1000;
  localparam int PWR_CY = 30 * CPM;
  localparam int POR_CY = 50 * CPM;

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] fail_at;
    logic [3:0] stage;
    logic       err;
    logic [7:0] nreq;
    logic [7:0] status;
    logic       rn;
    logic       pe;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h81, 8'hFF, 4'd4,  1'b0, 8'd0,  8'h00, 1'b1, 1'b1},
    '{8'h82, 8'hFF, 4'd5,  1'b0, 8'd1,  8'h00, 1'b1, 1'b1},
    '{8'h83, 8'hFF, 4'd6,  1'b0, 8'd8,  8'h00, 1'b1, 1'b1},
    '{8'h82, 8'd0,  4'd4,  1'b1, 8'd1,  8'h00, 1'b1, 1'b1},
    '{8'h84, 8'hFF, 4'd5,  1'b0, 8'd1,  8'h00, 1'b1, 1'b1},
    '{8'h84, 8'd0,  4'd0,  1'b1, 8'd1,  8'h00, 1'b1, 1'b1},
    '{8'h01, 8'd10, 4'd6,  1'b1, 8'd11, 8'h00, 1'b1, 1'b1},
    '{8'h01, 8'hFF, 4'd9,  1'b0, 8'd19, 8'h03, 1'b1, 1'b1},
    '{8'h00, 8'hFF, 4'd10, 1'b0, 8'd0,  8'h00, 1'b0, 1'b0}
  };

  localparam logic [7:0] BYTES [18] = '{
    8'h06, 8'h0B, 8'h17, 8'h38, 8'h9F, 8'hD9, 8'h80,
    8'h07, 8'h09, 8'h39, 8'h4F, 8'h00, 8'h65, 8'hB7, 8'h10,
    8'h0F, 8'h0C, 8'h09
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] mode = 8'h00;
  logic chip_reset_n, pwr_en, pwr_off, req_valid, req_write;
  logic [6:0] req_dev;
  logic [7:0] req_reg, req_data, status;
  logic [3:0] stage;
  logic busy, error;
  logic req_done = 1'b0;
  logic req_ok = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  demod_bringup #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .chip_reset_n(chip_reset_n), .pwr_en(pwr_en), .pwr_off(pwr_off),
    .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
    .req_reg(req_reg), .req_data(req_data), .req_done(req_done), .req_ok(req_ok),
    .status(status), .stage(stage), .busy(busy), .error(error)
  );

  // engine model and pin monitor, both on the falling edge
  int nreq = 0;
  int fail_at = 255;
  int eng_wait = 0;
  bit eng_busy = 0;
  logic       log_w   [32];
  logic [6:0] log_dev [32];
  logic [7:0] log_reg [32];
  logic [7:0] log_dat [32];
  int cyc = 0;
  int t_pwr = 0, t_rel = 0, t_req = 0;
  bit seen_req = 0;
  bit order_bad = 0;
  logic pe_prev = 0, rn_prev = 0;
  logic [3:0] stage_prev = 0;
  logic [3:0] stg_log [8];
  int nstg = 0;

  always @(negedge clk) begin
    cyc++;
    if (req_done) begin
      req_done = 1'b0;
      eng_busy = 0;
    end else if (eng_busy) begin
      if (eng_wait == 0) begin
        req_done = 1'b1;
        req_ok   = ((nreq - 1) != fail_at);
      end else eng_wait--;
    end else if (req_valid) begin
      if (nreq < 32) begin
        log_w[nreq] = req_write; log_dev[nreq] = req_dev;
        log_reg[nreq] = req_reg; log_dat[nreq] = req_data;
      end
      if (!seen_req) begin t_req = cyc; seen_req = 1; end
      nreq++;
      eng_busy = 1;
      eng_wait = 1;
    end
    if (!rst) begin
      if (pwr_en && !pe_prev) begin
        t_pwr = cyc;
        if (chip_reset_n) order_bad = 1;
      end
      if (chip_reset_n && !rn_prev) t_rel = cyc;
      if (req_valid && !chip_reset_n) order_bad = 1;
      if (stage != stage_prev && nstg < 8) begin stg_log[nstg] = stage; nstg++; end
    end
    pe_prev = pwr_en; rn_prev = chip_reset_n; stage_prev = stage;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input logic [7:0] m, input int f);
    nreq = 0; fail_at = f; seen_req = 0; nstg = 0;
    pulse(m);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_reg(input int j);
    if (j < 7) return 8'h06 + 8'(j);
    else if (j < 15) return 8'h07 + 8'(j - 7);
    else return 8'h0F + 8'(j - 15);
  endfunction

  task automatic check_seq(input string req);
    int bad = -1;
    for (int k = 0; k < nreq && k < 32; k++) begin
      if (log_dev[k] != 7'h08) bad = k;
      else if (k == 0 && (log_w[k] != 1'b0 || log_reg[k] != 8'hA2)) bad = k;
      else if (k > 0 && (log_w[k] != 1'b1 || log_reg[k] != exp_reg(k - 1) ||
                         log_dat[k] != BYTES[k - 1])) bad = k;
      if (bad >= 0) break;
    end
    check(bad < 0, req, "request list first mismatch index", bad, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(chip_reset_n == 0 && pwr_en == 0 && pwr_off == 1 && req_valid == 0,
          "R1", "pins in reset", {chip_reset_n, pwr_en, pwr_off, req_valid}, 4'b0010);
    check(status == 0 && stage == 0 && busy == 0 && error == 0,
          "R1", "status/stage/busy/error", {status, stage, busy, error}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run(VECS[v].mode, VECS[v].fail_at == 8'hFF ? 255 : int'(VECS[v].fail_at));
      // R9 R10 R5 R8 R12: final stage, error, status, request count, pins
      check(stage == VECS[v].stage, "R9", "stage", stage, VECS[v].stage);
      check(error == VECS[v].err, "R5", "error", error, VECS[v].err);
      check(status == VECS[v].status, "R8", "status", status, VECS[v].status);
      check(nreq == int'(VECS[v].nreq), "R7", "request count", nreq, VECS[v].nreq);
      check(chip_reset_n == VECS[v].rn && pwr_en == VECS[v].pe && pwr_off == !VECS[v].pe,
            "R12", "pins", {chip_reset_n, pwr_en, pwr_off}, {VECS[v].rn, VECS[v].pe, !VECS[v].pe});
      if (nreq > 0) check_seq("R6");
      if (v == 0) begin
        check(t_rel - t_pwr >= PWR_CY && t_rel - t_pwr <= PWR_CY + 4,
              "R3", "settle cycles", t_rel - t_pwr, PWR_CY);
        check(nstg == 4 && stg_log[0] == 1 && stg_log[1] == 2 && stg_log[2] == 3 &&
              stg_log[3] == 4, "R2", "stage steps", nstg, 4);
      end
      if (v == 1)
        check(t_req - t_rel >= POR_CY && t_req - t_rel <= POR_CY + 6,
              "R4", "por cycles", t_req - t_rel, POR_CY);
    end
    check(!order_bad, "R2", "power/reset/request order", order_bad, 0);

    // R11: status-only mode changes nothing
    pulse(8'h80); @(negedge clk);
    check(status == 0 && stage == 10 && error == 0 && pwr_en == 0 && chip_reset_n == 0 && !busy,
          "R11", "peek mode state", {status, stage, error}, {8'h00, 4'd10, 1'b0});

    // R14: unknown code
    pulse(8'h55); @(negedge clk);
    check(error == 1 && stage == 10 && pwr_en == 0 && pwr_off == 1 && status == 0 && !busy,
          "R14", "unknown mode", {error, stage, pwr_en}, {1'b1, 4'd10, 1'b0});
    pulse(8'h80); @(negedge clk);
    check(error == 1, "R11", "peek keeps error", error, 1);

    // R13: shutdown strobe during a full run is ignored
    nreq = 0; fail_at = 255;
    pulse(8'h01);
    while (stage != 4'd2) @(negedge clk);
    pulse(8'h00);
    @(negedge clk);
    check(pwr_en == 1 && busy == 1, "R13", "run continues", {pwr_en, busy}, 2'b11);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(stage == 9 && status == 8'h03 && error == 0, "R13", "run completed",
          {status, stage}, {8'h03, 4'd9});

    // R12: shutdown on the next clock
    @(negedge clk); start = 1'b1; mode = 8'h00;
    @(negedge clk); start = 1'b0;
    check(!chip_reset_n && !pwr_en && pwr_off && status == 0 && stage == 10 && !busy,
          "R12", "shutdown next clock", {chip_reset_n, pwr_en, pwr_off, status}, 11'b00100000000);

    // R1: reset in the middle of a run
    pulse(8'h01);
    while (stage != 4'd3) @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    check(!chip_reset_n && !pwr_en && pwr_off && !req_valid && !busy && stage == 0 && status == 0,
          "R1", "mid-run reset", {chip_reset_n, pwr_en, busy, stage}, 7'b0000000);
    rst = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule